// File: doc/BRIEF.md
# Branch Target Address Generator

This block computes the target address of a taken branch for a processor with a 24-bit address space. It supports two modes. In relative mode it sign-extends an 8-bit or 16-bit displacement and adds it to the address of the instruction that follows the branch. In pointer mode it treats an 8-bit operand as an address in the lowest 256 bytes of memory. It reads a 32-bit branch address from that location over a 16-bit read port and uses the low 24 bits of that value as the target.

A request is a one-cycle `start_i` together with the mode, the displacement width, the operand and the next-instruction address. The result appears on `target_o` together with a one-cycle `target_valid_o`. An odd target raises `misalign_o` in the same cycle, and the address is still presented. While a pointer fetch is in progress, `busy_o` is high and new requests are dropped.

Top module: `brt_unit`

## Requirements
- R1: With `mode_i`=0 (relative) and `disp_wide_i`=0, the displacement is `operand_i[7:0]`, sign-extended. `target_valid_o` is high in the cycle after the start cycle, and `target_o` equals `next_pc_i` plus the extended displacement.
- R2: With `mode_i`=0 and `disp_wide_i`=1, the displacement is `operand_i[15:0]`, sign-extended, and the latency is the same as in R1.
- R3: Every presented target has bits 31:24 equal to zero. The relative sum wraps modulo 2^24.
- R4: Whenever `target_valid_o` is high, `misalign_o` equals bit 0 of `target_o`. An odd target is still presented in full.
- R5: With `mode_i`=1 (pointer) and an even pointer `operand_i[7:0]`, the block makes exactly two reads:
  - The first read is at the zero-extended pointer and the second is at the pointer plus 2.
  - A read completes at a clock edge where `mem_req_o` and `mem_ready_i` are both high.
  - `mem_req_o` and `mem_addr_o` stay stable until that edge.
- R6: The pointer-mode target is {8'h00, bits 7:0 of the first read word, the second read word}. This is a big-endian longword with its top byte dropped. `target_valid_o` is high in the cycle after the edge where the second read completes.
- R7: An odd pointer causes no read. In the cycle after start, the block presents the zero-extended pointer with `target_valid_o` and `misalign_o` both high.
- R8: A `start_i` while `busy_o` is high is ignored. It produces no result and no extra read.
- R9: After reset, `target_valid_o`, `mem_req_o` and `busy_o` are low. `mem_req_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | request strobe |
| mode_i | input | 1 | 0 relative, 1 pointer |
| disp_wide_i | input | 1 | relative mode: 0 selects an 8-bit displacement, 1 selects a 16-bit displacement |
| operand_i | input | 16 | displacement, or the pointer in bits 7:0 |
| next_pc_i | input | 24 | address of the next instruction |
| mem_req_o | output | 1 | read request |
| mem_addr_o | output | 24 | read address |
| mem_ready_i | input | 1 | read completes at this edge, with the data |
| mem_rdata_i | input | 16 | read data |
| busy_o | output | 1 | pointer fetch in progress |
| target_valid_o | output | 1 | target valid strobe |
| target_o | output | 32 | branch target |
| misalign_o | output | 1 | target is odd |

## Verification
A fetch state machine stuck in a state, or leaving one too early, shows up at once. The bench would see the wrong number of reads, a read at the wrong address, or a result strobe in the wrong cycle relative to the last completed read. A stale word register or a wrong half-word order corrupts the next pointer-mode target, and the bench checks that target against a memory model on the same cycle the strobe appears. Because a random number of wait cycles is inserted before each read, handshake mistakes such as dropping a request early cannot hide behind fixed timing.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HI   = 2'd1,
    FS_LO   = 2'd2
  } fetch_state_e;

  localparam logic MODE_REL = 1'b0;
  localparam logic MODE_PTR = 1'b1;
endpackage

// File: rtl/brt_rel_adder.sv
module brt_rel_adder #(
  parameter int AW      = 24,
  parameter int LONG_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [AW-1:0]     next_pc_i,
  input  logic [LONG_W-1:0] disp_i,
  input  logic              wide_i,
  output logic [AW-1:0]     sum_o
);
  logic [AW-1:0] ext_long, ext_short;

  assign ext_long  = {{(AW-LONG_W){disp_i[LONG_W-1]}}, disp_i};
  assign ext_short = {{(AW-SHORT_W){disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
  // sum wraps in the AW-bit space
  assign sum_o = next_pc_i + (wide_i ? ext_long : ext_short);
endmodule

// File: rtl/brt_fetch.sv
module brt_fetch
  import brt_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_ready_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic [AW-1:0]    word_o
);
  localparam int HW = AW - DW;           // bits kept from the high word
  localparam int BYTES_PER_WORD = DW / 8;

  fetch_state_e state_q, state_d;
  logic [PTR_W-1:0] ptr_q;
  logic [HW-1:0]    hi_q;
  logic [AW-1:0]    base_addr;

  assign base_addr = {{(AW-PTR_W){1'b0}}, ptr_q};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (launch_i) state_d = FS_HI;
      FS_HI:   if (mem_ready_i) state_d = FS_LO;
      FS_LO:   if (mem_ready_i) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      ptr_q   <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == FS_IDLE && launch_i) ptr_q <= ptr_i;
      if (state_q == FS_HI && mem_ready_i) hi_q <= mem_rdata_i[HW-1:0];
    end
  end

  assign busy_o     = (state_q != FS_IDLE);
  assign mem_req_o  = (state_q == FS_HI) || (state_q == FS_LO);
  assign mem_addr_o = (state_q == FS_LO) ? base_addr + AW'(BYTES_PER_WORD) : base_addr;
  assign done_o     = (state_q == FS_LO) && mem_ready_i;
  assign word_o     = {hi_q, mem_rdata_i};
endmodule

// File: rtl/brt_unit.sv
module brt_unit
  import brt_pkg::*;
#(
  parameter int AW    = 24,
  parameter int TW    = 32,
  parameter int DW    = 16,
  parameter int PTR_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          disp_wide_i,
  input  logic [15:0]   operand_i,
  input  logic [AW-1:0] next_pc_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          target_valid_o,
  output logic [TW-1:0] target_o,
  output logic          misalign_o
);
  localparam int PAD_W = TW - AW;

  logic          accept, rel_go, ptr_odd_go, launch;
  logic [AW-1:0] rel_sum, fetch_word, ptr_ext;
  logic          fetch_done;

  assign accept     = start_i && !busy_o;
  assign rel_go     = accept && (mode_i == MODE_REL);
  assign ptr_odd_go = accept && (mode_i == MODE_PTR) && operand_i[0];
  assign launch     = accept && (mode_i == MODE_PTR) && !operand_i[0];
  assign ptr_ext    = {{(AW-PTR_W){1'b0}}, operand_i[PTR_W-1:0]};

  brt_rel_adder #(.AW(AW), .LONG_W(16), .SHORT_W(8)) u_add (
    .next_pc_i (next_pc_i),
    .disp_i    (operand_i),
    .wide_i    (disp_wide_i),
    .sum_o     (rel_sum)
  );

  brt_fetch #(.AW(AW), .DW(DW), .PTR_W(PTR_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .ptr_i       (operand_i[PTR_W-1:0]),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (fetch_done),
    .word_o      (fetch_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_valid_o <= 1'b0;
      target_o       <= '0;
      misalign_o     <= 1'b0;
    end else begin
      target_valid_o <= 1'b0;
      if (rel_go) begin
        target_valid_o <= 1'b1;
        target_o       <= {{PAD_W{1'b0}}, rel_sum};
        misalign_o     <= rel_sum[0];
      end else if (ptr_odd_go) begin
        target_valid_o <= 1'b1;
        target_o       <= {{PAD_W{1'b0}}, ptr_ext};
        misalign_o     <= 1'b1;
      end else if (fetch_done) begin
        target_valid_o <= 1'b1;
        target_o       <= {{PAD_W{1'b0}}, fetch_word};
        misalign_o     <= fetch_word[0];
      end
    end
  end
endmodule

// File: rtl/brt_unit_chk.sv
module brt_unit_chk #(
  parameter int AW = 24,
  parameter int TW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mode_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          target_valid_o,
  input logic [TW-1:0] target_o,
  input logic          misalign_o
);
  AST_REL_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !mode_i |=> target_valid_o); // R1
  AST_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_valid_o |-> target_o[TW-1:AW] == '0); // R3
  AST_ODD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_valid_o |-> misalign_o == target_o[0]); // R4
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)); // R5
  AST_LOW_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o >> 9) == '0); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R9
endmodule

bind brt_unit brt_unit_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .mode_i         (mode_i),
  .busy_o         (busy_o),
  .mem_req_o      (mem_req_o),
  .mem_ready_i    (mem_ready_i),
  .mem_addr_o     (mem_addr_o),
  .target_valid_o (target_valid_o),
  .target_o       (target_o),
  .misalign_o     (misalign_o)
);

// File: tb/brt_unit_bench.sv
module brt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0, wide = 1'b0;
  logic [15:0] operand = '0;
  logic [23:0] next_pc = '0;
  logic        mem_req, mem_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        busy, tvalid, misalign;
  logic [31:0] target;

  int total = 0, bad = 0;
  int rd_total = 0, cyc = 0, hs_cyc = -10, wait_cnt = 0;
  logic [23:0] addr_last = '0, addr_prev = '0;

  always #5 clk = ~clk;

  brt_unit u_brt_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .disp_wide_i(wide), .operand_i(operand), .next_pc_i(next_pc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .target_valid_o(tvalid),
    .target_o(target), .misalign_o(misalign)
  );

  function automatic logic [15:0] mem_word(logic [23:0] a);
    return (a[15:0] * 16'h3B71) ^ 16'hC6A5;
  endfunction

  function automatic logic [31:0] exp_rel(logic w, logic [15:0] d, logic [23:0] pc);
    logic [23:0] s;
    s = w ? pc + {{8{d[15]}}, d} : pc + {{16{d[7]}}, d[7:0]};
    return {8'h00, s};
  endfunction

  function automatic logic [31:0] exp_ptr(logic [7:0] p);
    logic [15:0] hi, lo;
    hi = mem_word({16'h0, p});
    lo = mem_word({16'h0, p} + 24'd2);
    return {8'h00, hi[7:0], lo};
  endfunction

  // memory model: handshake counted at posedge, responses driven at negedge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ready) begin
      rd_total  <= rd_total + 1;
      hs_cyc    <= cyc;
      addr_prev <= addr_last;
      addr_last <= mem_addr;
    end
  end

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      wait_cnt  <= int'($urandom_range(0, 2));
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ready <= 1'b1;
        mem_rdata <= mem_word(mem_addr);
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_rel(logic w, logic [15:0] d, logic [23:0] pc);
    logic [31:0] e;
    e = exp_rel(w, d, pc);
    @(negedge clk);
    start = 1'b1; mode = 1'b0; wide = w; operand = d; next_pc = pc;
    @(negedge clk);
    start = 1'b0;
    check(w ? "R2 valid" : "R1 valid", {31'd0, tvalid}, 32'd1);
    check(w ? "R2 target" : "R1 target", target, e);
    check("R4 misalign", {31'd0, misalign}, {31'd0, e[0]});
  endtask

  task automatic do_ptr(logic [7:0] p, bit inject);
    int base, n;
    logic [31:0] e;
    bit got;
    base = rd_total;
    @(negedge clk);
    start = 1'b1; mode = 1'b1; operand = {8'($urandom), p};
    @(negedge clk);
    start = 1'b0;
    if (p[0]) begin
      check("R7 valid", {31'd0, tvalid}, 32'd1);
      check("R7 target", target, {24'd0, p});
      check("R7 misalign", {31'd0, misalign}, 32'd1);
      repeat (3) @(negedge clk);
      check("R7 no reads", rd_total - base, 0);
      return;
    end
    e = exp_ptr(p);
    got = 0;
    for (int i = 0; i < 60; i++) begin
      if (tvalid) begin got = 1; break; end
      if (inject && i == 0) begin
        start = 1'b1; mode = 1'b0; wide = 1'b1; operand = 16'h0042; next_pc = 24'h000100;
      end else if (inject && i == 1) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R6 valid seen", {31'd0, got}, 32'd1);
    check("R5 read count", rd_total - base, 2);
    check("R5 first addr", {8'd0, addr_prev}, {24'd0, p});
    check("R5 second addr", {8'd0, addr_last}, {24'd0, p} + 32'd2);
    check("R6 latency", cyc - hs_cyc, 1);
    check("R6 target", target, e);
    check("R4 misalign", {31'd0, misalign}, {31'd0, e[0]});
    if (inject) check("R8 busy start ignored", target, e);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R9 valid reset", {31'd0, tvalid}, 32'd0);
    check("R9 req reset", {31'd0, mem_req}, 32'd0);
    check("R9 busy reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    do_rel(1'b0, 16'h0080, 24'h000200);   // R1 -128
    do_rel(1'b0, 16'hFF7F, 24'h000200);   // R1 +127, high byte ignored
    do_rel(1'b1, 16'h8000, 24'h000010);   // R2 + R3 wrap below zero
    do_rel(1'b1, 16'h7FFF, 24'hFFFF00);   // R3 wrap above top
    do_rel(1'b0, 16'h0001, 24'h001000);   // R4 odd target
    do_ptr(8'h00, 0);
    do_ptr(8'hFE, 0);                     // R5 second read at 0x100
    do_ptr(8'h33, 0);                     // R7
    do_ptr(8'h40, 1);                     // R8
    // random
    for (int k = 0; k < 60; k++)
      do_rel(1'($urandom), 16'($urandom), 24'($urandom));
    for (int k = 0; k < 30; k++)
      do_ptr(8'($urandom), 1'($urandom));
    @(negedge clk);
    check("R9 idle no req", {31'd0, mem_req}, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule